// File: doc/BRIEF.md
# Self-Triggered Segmented Waveform Buffer

This block is the digital control for a derandomizing waveform memory. A fast sample stream is written continuously into one short active segment of a segmented store. A hit flag on a sample freezes that segment and queues it as an event. Writing then moves straight on to the next segment, so capture never pauses for readout.

Queued events are drained in arrival order through a valid/ready readout port, at whatever pace the digitizer side accepts them, while writing carries on. A second-level skip command throws away the event at the head of the queue without reading it out. When every segment holds an event, further hits are lost and counted.

The store is modelled as a RAM of `SEGS * SEG_LEN` words. Both `SEGS` and `SEG_LEN` must be powers of two. The defaults are 128 segments of 32 samples.

Top module: `seg_wave_buffer`

## Requirements
- R1: After reset, `out_valid`, `drop` and `ovf_count` are 0 and `free_segs` equals `SEGS`.
- R2: Storing a sample:
  - Each cycle with `in_valid` high, while a segment is free, stores `in_data` in the active segment at the current write offset.
  - The write offset then advances by one, modulo `SEG_LEN`.
  - An event's samples are read out in offset order, from 0 to `SEG_LEN-1`.
- R3: A cycle with `in_valid` and `in_hit` high, while a segment is free, does three things:
  - it stores that sample;
  - it queues the active segment as an event;
  - it makes segment (index+1) mod `SEGS` the active one, with no pause in writing.
- R4: Events leave the readout port in the order they were queued. `out_seg` gives the segment index of the head event.
- R5: While the first sample of an event is presented, `out_ts` equals the number of `in_valid` cycles since reset that came before the hit sample, modulo 2^`TSW`.
- R6: `out_first` is high exactly on offset 0 of an event, and `out_last` is high exactly on offset `SEG_LEN-1`.
- R7: Readout handshake:
  - `out_valid` is high whenever an event is queued and `skip` is low.
  - A sample is consumed only in a cycle where both `out_valid` and `out_ready` are high.
  - Otherwise the presented sample is held.
  - Consuming the last sample dequeues the event.
- R8: A cycle with `skip` high and an event queued discards the head event, including any samples of it not yet read. `out_valid` is low during that cycle.
- R9: `free_segs` equals `SEGS` minus the number of queued events.
- R10: Behaviour while full (`free_segs` = 0):
  - `in_valid` samples are not stored, and hits are not queued.
  - Each lost hit raises `drop` for one cycle, in the cycle after it.
  - Each lost hit increments `ovf_count`, which saturates at all ones.
- R11: Writing into the active segment and reading of queued events go on in the same cycles without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present |
| in_data | input | DW | Sample value |
| in_hit | input | 1 | Self-trigger on this sample |
| skip | input | 1 | Discard head event |
| out_valid | output | 1 | Readout sample valid |
| out_ready | input | 1 | Readout sample accepted |
| out_data | output | DW | Readout sample |
| out_first | output | 1 | First sample of event |
| out_last | output | 1 | Last sample of event |
| out_seg | output | $clog2(SEGS) | Segment index of head event |
| out_ts | output | TSW | Freeze timestamp of head event |
| free_segs | output | $clog2(SEGS+1) | Number of free segments |
| drop | output | 1 | Hit lost on previous cycle |
| ovf_count | output | OVW | Saturating lost-hit count |

## Verification
The readout outputs and `free_segs` are decoded straight from registered state. The effect of the inputs of one cycle therefore appears just after the following rising edge. `drop` is registered from the lost hit, so it appears in that same next cycle and not in the cycle of the hit.

The bench drives inputs on the falling edge and compares one time unit later, before the rising edge. It then advances its reference queue, so every expectation refers to the state left by the previous edge.

// File: rtl/seg_wave_buffer.sv
module seg_wave_buffer #(
  parameter int SEGS    = 128,
  parameter int SEG_LEN = 32,
  parameter int DW      = 12,
  parameter int TSW     = 16,
  parameter int OVW     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [DW-1:0]              in_data,
  input  logic                       in_hit,
  input  logic                       skip,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [DW-1:0]              out_data,
  output logic                       out_first,
  output logic                       out_last,
  output logic [$clog2(SEGS)-1:0]    out_seg,
  output logic [TSW-1:0]             out_ts,
  output logic [$clog2(SEGS+1)-1:0]  free_segs,
  output logic                       drop,
  output logic [OVW-1:0]             ovf_count
);
  localparam int SW = $clog2(SEGS);
  localparam int OW = $clog2(SEG_LEN);
  localparam int CW = $clog2(SEGS+1);

  logic [DW-1:0]  mem   [SEGS*SEG_LEN];
  logic [TSW-1:0] stamp [SEGS];

  logic [SW-1:0]  wr_seg, rd_seg;
  logic [OW-1:0]  wr_off, rd_off;
  logic [CW-1:0]  used;
  logic [TSW-1:0] ts;

  wire full     = (used == CW'(SEGS));
  wire have     = (used != '0);
  wire wr_en    = in_valid && !full;
  wire push     = wr_en && in_hit;
  wire hit_lost = in_valid && in_hit && full;
  wire xfer     = out_valid && out_ready;
  wire at_end   = (rd_off == OW'(SEG_LEN-1));
  wire skip_pop = skip && have;
  wire pop      = skip_pop || (xfer && at_end);

  assign out_valid = have && !skip;
  assign out_data  = mem[{rd_seg, rd_off}];
  assign out_first = (rd_off == '0);
  assign out_last  = at_end;
  assign out_seg   = rd_seg;
  assign out_ts    = stamp[rd_seg];
  assign free_segs = CW'(SEGS) - used;

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_seg, wr_off}] <= in_data;
    if (push)  stamp[wr_seg] <= ts;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_seg    <= '0;
      wr_off    <= '0;
      rd_seg    <= '0;
      rd_off    <= '0;
      used      <= '0;
      ts        <= '0;
      drop      <= 1'b0;
      ovf_count <= '0;
    end else begin
      if (in_valid) ts <= ts + 1'b1;
      if (wr_en)    wr_off <= wr_off + 1'b1;
      if (push)     wr_seg <= wr_seg + 1'b1;
      if (skip_pop)  rd_off <= '0;
      else if (xfer) rd_off <= rd_off + 1'b1;
      if (pop)      rd_seg <= rd_seg + 1'b1;
      used <= used + CW'(push) - CW'(pop);
      drop <= hit_lost;
      if (hit_lost && ovf_count != '1) ovf_count <= ovf_count + 1'b1;
    end
  end

  // R9
  free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_segs <= CW'(SEGS));

  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> skip || ($stable(out_data) && $stable(out_seg) && $stable(out_first)));

  // R10
  lost_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_hit && free_segs == '0 |=> drop);

  // R10
  ovf_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_count >= $past(ovf_count));

  // R6
  next_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid || out_first);

  // R8
  skip_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> !out_valid);
endmodule

// File: tb/tb_seg_wave_buffer.sv
module tb_seg_wave_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int SEGS = 128, SEG_LEN = 32, DW = 12, TSW = 16, OVW = 8;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_hit = 0, skip = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, out_first, out_last, drop;
  logic [DW-1:0] out_data;
  logic [6:0] out_seg;
  logic [TSW-1:0] out_ts;
  logic [7:0] free_segs;
  logic [OVW-1:0] ovf_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_wave_buffer #(.SEGS(SEGS), .SEG_LEN(SEG_LEN), .DW(DW), .TSW(TSW), .OVW(OVW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_hit(in_hit),
    .skip(skip), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last), .out_seg(out_seg), .out_ts(out_ts),
    .free_segs(free_segs), .drop(drop), .ovf_count(ovf_count));

  int checks = 0, fails = 0;
  logic [DW-1:0]  mmem [SEGS][SEG_LEN];
  bit             mok  [SEGS][SEG_LEN];
  logic [TSW-1:0] mtsq [SEGS];
  int mwr = 0, mwo = 0, mrd = 0, mro = 0, mcnt = 0, movf = 0;
  logic [TSW-1:0] mscnt = '0;
  bit mdrop = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_valid(input bit sk);
    return mcnt != 0 && !sk;
  endfunction

  task automatic cyc(input bit v, input logic [DW-1:0] d, input bit h, input bit sk, input bit rdy);
    bit ev, full, pop;
    @(negedge clk);
    in_valid = v; in_data = d; in_hit = h; skip = sk; out_ready = rdy;
    #1;
    ev = exp_valid(sk);
    full = (mcnt == SEGS);
    chk(out_valid == ev, sk ? "R8 out_valid" : "R7 out_valid", out_valid, ev);
    chk(free_segs == SEGS - mcnt, "R9 free_segs", free_segs, SEGS - mcnt);
    chk(drop == mdrop, "R10 drop", drop, mdrop);
    chk(ovf_count == movf, "R10 ovf_count", ovf_count, movf);
    if (ev) begin
      if (mok[mrd][mro])
        chk(out_data === mmem[mrd][mro], (v && !full) ? "R11 out_data" : "R2 out_data",
            out_data, mmem[mrd][mro]);
      chk(out_seg == mrd, "R4 out_seg", out_seg, mrd);
      chk(out_first == (mro == 0) && out_last == (mro == SEG_LEN-1), "R6 first/last",
          {out_first, out_last}, {mro == 0, mro == SEG_LEN-1});
      if (mro == 0) chk(out_ts == mtsq[mrd], "R5 out_ts", out_ts, mtsq[mrd]);
    end
    pop = 0;
    if (ev && rdy) begin
      if (mro == SEG_LEN-1) pop = 1;
      mro = (mro + 1) % SEG_LEN;
    end
    if (sk && mcnt != 0) begin pop = 1; mro = 0; end
    mdrop = v && h && full;
    if (mdrop && movf < 255) movf++;
    if (v && !full) begin
      mmem[mwr][mwo] = d; mok[mwr][mwo] = 1;
      if (h) begin
        mtsq[mwr] = mscnt; mwr = (mwr + 1) % SEGS; mcnt++;
        for (int k = 0; k < SEG_LEN; k++) mok[mwr][k] = mok[mwr][k];
      end
      mwo = (mwo + 1) % SEG_LEN;
    end
    if (v) mscnt++;
    if (pop) begin mrd = (mrd + 1) % SEGS; mcnt--; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    for (int s = 0; s < SEGS; s++) for (int k = 0; k < SEG_LEN; k++) mok[s][k] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(free_segs == SEGS, "R1 free_segs", free_segs, SEGS);
    chk(ovf_count == 0 && drop == 0, "R1 ovf/drop", {ovf_count, drop}, 0);
    @(negedge clk); rst_n = 1;
    // R2 R3 directed: one full segment then a hit, read back with ready held low first
    for (int i = 0; i < SEG_LEN; i++) cyc(1, DW'(i + 100), i == SEG_LEN-1, 0, 0);
    for (int i = 0; i < 5; i++) cyc(1, DW'(i + 500), 0, 0, 0);
    for (int i = 0; i < SEG_LEN; i++) cyc(0, '0, 0, 0, 1);
    // R8 directed skip mid-event
    cyc(1, 12'h7, 1, 0, 1);
    cyc(0, '0, 0, 0, 1);
    cyc(0, '0, 0, 1, 1);
    cyc(0, '0, 0, 0, 1);
    // random streaming with concurrent readout (R11)
    for (int i = 0; i < 4000; i++)
      cyc($urandom_range(0, 9) < 8, DW'($urandom), $urandom_range(0, 39) == 0,
          $urandom_range(0, 99) == 0, $urandom_range(0, 3) != 0);
    // R10 fill all segments and saturate the lost-hit counter
    for (int i = 0; i < 1500; i++) cyc(1, DW'($urandom), (i % 3) == 0, 0, 0);
    chk(ovf_count == 255, "R10 ovf saturation", ovf_count, 255);
    // drain and keep streaming
    for (int i = 0; i < 8000; i++)
      cyc($urandom_range(0, 1) == 1, DW'($urandom), $urandom_range(0, 59) == 0,
          $urandom_range(0, 49) == 0, $urandom_range(0, 3) != 0);
    for (int i = 0; i < 6000; i++) cyc(0, '0, 0, 0, 1);
    chk(free_segs == SEGS, "R9 drained", free_segs, SEGS);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule